// File: doc/BRIEF.md
# Chip Low-Power Mode Controller

This controller runs on an always-on clock and moves a chip with several power domains among four operating modes: functional, doze, deep sleep and power down. Software writes a mode request with a 2-bit code. A power-down request also carries a domain selection, or a flag that selects every gated domain. The controller drives the global clock gate, the enable of the clock source (PLL), one power-switch enable per domain and one reset hold per domain. It reports the current mode and the set of domains that are fully up.

Each mode has its own way out. Doze closes only the global clock gate, and a software request for the functional mode reopens it without any reset. Deep sleep also stops the clock source, and only the hardware reset `rst_n` brings the chip back. Power down switches off the selected domains while the other domains keep running. A later request for the functional mode restores the switched-off domains one at a time, in ascending index order. Each restored domain stays in reset until its switch reports power good. The PLL and the supply switches are modelled only as acknowledge inputs (`pll_lock`, `dom_pgood`).

Top module: `lpm_ctrl`

## Requirements
- R1: After `rst_n` is released, `pll_en` is 1 and `clk_gate_en` stays 0 until `pll_lock` is seen high. All domains are then powered up in index order, and `busy` stays 1 until the last one is out of reset. At that point `stat_mode` is 0 and `clk_gate_en` is 1.
- R2: A request (`req_valid` high for one cycle) uses these codes in `req_mode`: 0 functional, 1 doze, 2 deep sleep, 3 power down. In the functional mode an accepted entry request raises `busy` and is held off while `unit_busy` is 1. It takes effect on the cycle after `unit_busy` is seen low.
- R3: A request written while `busy` is 1 is ignored and does not change the mode finally reached.
- R4: Doze sets `clk_gate_en` to 0, keeps `pll_en` at 1 and leaves `dom_pwr_en` unchanged, and `stat_mode` reads 1. A code-0 request returns to the functional mode without a reset.
- R5: Deep sleep drops `clk_gate_en` at least one cycle before `pll_en` falls, and `stat_mode` reads 2. Every request is ignored there, and only `rst_n` leaves it.
- R6: A partial power down (`req_full` is 0) clears `dom_pwr_en` and sets `dom_rst_hold` for exactly the domains whose bits are set in `req_dom_sel`. The other domains stay enabled, `clk_gate_en` stays 1, and `stat_mode` reads 3.
- R7: A full power down (`req_full` is 1) switches off every domain, whatever the value of `req_dom_sel`.
- R8: Leaving power down enables only the domains that are off. They are enabled one per step in ascending index order, and a domain is not enabled before the previous one has reported power good.
- R9: The reset hold of a domain is released only after its `dom_pgood` has been seen high, and it is always set while the domain's switch is off.
- R10: In doze and in power down, every request other than code 0 is ignored.
- R11: Bit i of `stat_pwr_mask` is 1 exactly when domain i is enabled and out of reset hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| req_valid | input | 1 | One-cycle strobe of a mode request write |
| req_mode | input | 2 | Requested mode code |
| req_full | input | 1 | Power down of all gated domains |
| req_dom_sel | input | NUM_DOM | Domains to switch off in a partial power down |
| unit_busy | input | 1 | The chip is fully in use, so mode entry is held off |
| pll_lock | input | 1 | Clock source reports lock |
| dom_pgood | input | NUM_DOM | Power-good acknowledges from the domain switches |
| clk_gate_en | output | 1 | Global clock gate open |
| pll_en | output | 1 | Clock source enable |
| dom_pwr_en | output | NUM_DOM | Per-domain power switch enables |
| dom_rst_hold | output | NUM_DOM | Per-domain reset holds |
| stat_mode | output | 2 | Current mode code |
| stat_pwr_mask | output | NUM_DOM | Domains enabled and out of reset |
| busy | output | 1 | Transition in progress; requests are ignored |

## Verification
The hardest condition to reach from the ports is a power-up step in which a domain is already switched on but has not yet reported power good. In that window the reset hold must stay set and the next domain must not be started. The bench drives the power-good acknowledges from a model with an adjustable delay. It stretches that delay for one full power-down exit and samples in the middle of the window. A second hard case is a write that arrives while an earlier request is still held off by `unit_busy`. The bench keeps `unit_busy` high, issues two requests back to back, and checks that only the first takes effect.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_DOZE = 2'd1,
    MODE_DSLP = 2'd2,
    MODE_PDN  = 2'd3
  } lpm_mode_e;

  typedef enum logic [2:0] {
    ST_LOCK = 3'd0,
    ST_PUP  = 3'd1,
    ST_RUN  = 3'd2,
    ST_DOZE = 3'd3,
    ST_DSG  = 3'd4,
    ST_DSLP = 3'd5,
    ST_PDN  = 3'd6
  } lpm_state_e;

endpackage

// File: rtl/lpm_dom_seq.sv
module lpm_dom_seq #(
  parameter int NUM_DOM = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               shut,
  input  logic [NUM_DOM-1:0] shut_mask,
  input  logic [NUM_DOM-1:0] pgood,
  output logic [NUM_DOM-1:0] pwr_en,
  output logic [NUM_DOM-1:0] rst_hold,
  output logic               run
);

  localparam int IDX_W = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_DOM - 1);

  logic [NUM_DOM-1:0] en_q, en_d;
  logic [NUM_DOM-1:0] hold_q, hold_d;
  logic               run_q, run_d;
  logic [IDX_W-1:0]   idx_q, idx_d;

  // Next state: switch-off, or one step of the ordered power-up walk
  always_comb begin
    en_d   = en_q;
    hold_d = hold_q;
    run_d  = run_q;
    idx_d  = idx_q;
    if (shut) begin
      en_d   = en_q & ~shut_mask;
      hold_d = hold_q | shut_mask;
    end
    if (start) begin
      run_d = 1'b1;
      idx_d = '0;
    end else if (run_q) begin
      if (!en_q[idx_q]) begin
        en_d[idx_q] = 1'b1;
      end else if (pgood[idx_q]) begin
        hold_d[idx_q] = 1'b0;
        if (idx_q == LAST_IDX) run_d = 1'b0;
        else                   idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      hold_q <= '1;
      run_q  <= 1'b0;
      idx_q  <= '0;
    end else begin
      en_q   <= en_d;
      hold_q <= hold_d;
      run_q  <= run_d;
      idx_q  <= idx_d;
    end
  end

  assign pwr_en   = en_q;
  assign rst_hold = hold_q;
  assign run      = run_q;

endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
  import lpm_pkg::*;
#(
  parameter int NUM_DOM = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [1:0]         req_mode,
  input  logic               req_full,
  input  logic [NUM_DOM-1:0] req_dom_sel,
  input  logic               unit_busy,
  input  logic               pll_lock,
  input  logic               seq_run,
  output logic               seq_start,
  output logic               seq_shut,
  output logic [NUM_DOM-1:0] shut_mask,
  output logic               clk_gate_en,
  output logic               pll_en,
  output logic [1:0]         stat_mode,
  output logic               busy
);

  lpm_state_e         st_q, st_d;
  logic               pend_q, pend_d;
  lpm_mode_e          pmode_q, pmode_d;
  logic [NUM_DOM-1:0] pmask_q, pmask_d;
  logic               accept;

  assign busy   = (st_q == ST_LOCK) || (st_q == ST_PUP) ||
                  (st_q == ST_DSG) || pend_q;
  assign accept = req_valid && !busy;

  always_comb begin
    st_d      = st_q;
    pend_d    = pend_q;
    pmode_d   = pmode_q;
    pmask_d   = pmask_q;
    seq_start = 1'b0;
    seq_shut  = 1'b0;
    shut_mask = pmask_q;
    unique case (st_q)
      ST_LOCK: if (pll_lock) begin
        st_d      = ST_PUP;
        seq_start = 1'b1;
      end
      ST_PUP: if (!seq_run) st_d = ST_RUN;
      ST_RUN: begin
        if (pend_q) begin
          if (!unit_busy) begin
            pend_d = 1'b0;
            unique case (pmode_q)
              MODE_DOZE: st_d = ST_DOZE;
              MODE_DSLP: st_d = ST_DSG;
              MODE_PDN: begin
                st_d     = ST_PDN;
                seq_shut = 1'b1;
              end
              default: st_d = ST_RUN;
            endcase
          end
        end else if (accept) begin
          pend_d  = 1'b1;
          pmode_d = lpm_mode_e'(req_mode);
          pmask_d = req_full ? '1 : req_dom_sel;
        end
      end
      ST_DOZE: if (accept && (req_mode == MODE_RUN)) st_d = ST_RUN;
      ST_DSG:  st_d = ST_DSLP;
      ST_DSLP: st_d = ST_DSLP;
      ST_PDN: if (accept && (req_mode == MODE_RUN)) begin
        st_d      = ST_PUP;
        seq_start = 1'b1;
      end
      default: st_d = ST_LOCK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_LOCK;
      pend_q  <= 1'b0;
      pmode_q <= MODE_RUN;
      pmask_q <= '0;
    end else begin
      st_q    <= st_d;
      pend_q  <= pend_d;
      pmode_q <= pmode_d;
      pmask_q <= pmask_d;
    end
  end

  always_comb begin
    clk_gate_en = (st_q == ST_PUP) || (st_q == ST_RUN) || (st_q == ST_PDN);
    pll_en      = (st_q != ST_DSLP);
    unique case (st_q)
      ST_DOZE:         stat_mode = MODE_DOZE;
      ST_DSG, ST_DSLP: stat_mode = MODE_DSLP;
      ST_PDN:          stat_mode = MODE_PDN;
      default:         stat_mode = MODE_RUN;
    endcase
  end

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl #(
  parameter int NUM_DOM = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [1:0]         req_mode,
  input  logic               req_full,
  input  logic [NUM_DOM-1:0] req_dom_sel,
  input  logic               unit_busy,
  input  logic               pll_lock,
  input  logic [NUM_DOM-1:0] dom_pgood,
  output logic               clk_gate_en,
  output logic               pll_en,
  output logic [NUM_DOM-1:0] dom_pwr_en,
  output logic [NUM_DOM-1:0] dom_rst_hold,
  output logic [1:0]         stat_mode,
  output logic [NUM_DOM-1:0] stat_pwr_mask,
  output logic               busy
);

  logic               seq_start, seq_shut, seq_run;
  logic [NUM_DOM-1:0] shut_mask;

  lpm_mode_fsm #(.NUM_DOM(NUM_DOM)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_mode(req_mode), .req_full(req_full),
    .req_dom_sel(req_dom_sel), .unit_busy(unit_busy), .pll_lock(pll_lock),
    .seq_run(seq_run), .seq_start(seq_start), .seq_shut(seq_shut),
    .shut_mask(shut_mask), .clk_gate_en(clk_gate_en), .pll_en(pll_en),
    .stat_mode(stat_mode), .busy(busy)
  );

  lpm_dom_seq #(.NUM_DOM(NUM_DOM)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start(seq_start), .shut(seq_shut), .shut_mask(shut_mask),
    .pgood(dom_pgood), .pwr_en(dom_pwr_en), .rst_hold(dom_rst_hold),
    .run(seq_run)
  );

  assign stat_pwr_mask = dom_pwr_en & ~dom_rst_hold;

endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk #(
  parameter int NUM_DOM = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_DOM-1:0] dom_pgood,
  input logic               clk_gate_en,
  input logic               pll_en,
  input logic [NUM_DOM-1:0] dom_pwr_en,
  input logic [NUM_DOM-1:0] dom_rst_hold,
  input logic [1:0]         stat_mode
);

  logic [NUM_DOM-1:0] en_prev;
  logic [NUM_DOM-1:0] en_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_prev <= '0;
    else        en_prev <= dom_pwr_en;
  end
  assign en_rise = dom_pwr_en & ~en_prev;

  // R8
  one_dom_per_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(en_rise) <= 1);

  // R8
  index_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_rise != '0) |-> (((en_rise - 1'b1) & ~dom_pwr_en) == '0));

  // R9
  hold_while_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~dom_pwr_en & ~dom_rst_hold) == '0));

  // R9
  hold_release_pgood_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(dom_rst_hold) & ~dom_rst_hold & ~$past(dom_pgood)) == '0));

  // R5
  gate_before_pll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_en) |-> !$past(clk_gate_en));

  // R5
  dslp_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_en |=> !pll_en);

  // R1
  gate_needs_pll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_gate_en) |-> pll_en);

  // R4
  doze_keeps_dom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_mode == 2'd1) |=> (dom_pwr_en == $past(dom_pwr_en)));

endmodule

bind lpm_ctrl lpm_ctrl_chk #(.NUM_DOM(NUM_DOM)) u_chk (
  .clk(clk), .rst_n(rst_n), .dom_pgood(dom_pgood),
  .clk_gate_en(clk_gate_en), .pll_en(pll_en), .dom_pwr_en(dom_pwr_en),
  .dom_rst_hold(dom_rst_hold), .stat_mode(stat_mode)
);

// File: tb/sim_lpm_ctrl.sv
module sim_lpm_ctrl;

  localparam int ND     = 4;
  localparam int CLK_PD = 10;

  logic          clk, rst_n;
  logic          req_valid, req_full, unit_busy, pll_lock;
  logic [1:0]    req_mode;
  logic [ND-1:0] req_dom_sel, dom_pgood;
  logic          clk_gate_en, pll_en, busy;
  logic [ND-1:0] dom_pwr_en, dom_rst_hold, stat_pwr_mask;
  logic [1:0]    stat_mode;

  int n_chk, n_fail, pg_dly;
  int exp_q[$];

  lpm_ctrl #(.NUM_DOM(ND)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .req_full(req_full), .req_dom_sel(req_dom_sel), .unit_busy(unit_busy),
    .pll_lock(pll_lock), .dom_pgood(dom_pgood), .clk_gate_en(clk_gate_en),
    .pll_en(pll_en), .dom_pwr_en(dom_pwr_en), .dom_rst_hold(dom_rst_hold),
    .stat_mode(stat_mode), .stat_pwr_mask(stat_pwr_mask), .busy(busy)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PD/2) clk = ~clk;
  end

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  // power-good model: each switch reports good pg_dly cycles after enable
  initial begin
    int cnt [ND];
    dom_pgood = '0;
    for (int i = 0; i < ND; i++) cnt[i] = 0;
    forever begin
      @(posedge clk);
      for (int i = 0; i < ND; i++) begin
        if (!dom_pwr_en[i]) begin
          cnt[i] = 0;
          dom_pgood[i] <= 1'b0;
        end else if (cnt[i] >= pg_dly) begin
          dom_pgood[i] <= 1'b1;
        end else begin
          cnt[i] = cnt[i] + 1;
        end
      end
    end
  end

  // scoreboard monitor: each switch-on event must match the next expected domain
  initial begin
    logic [ND-1:0] prev;
    prev = '0;
    forever begin
      @(negedge clk);
      for (int i = 0; i < ND; i++) begin
        if (dom_pwr_en[i] && !prev[i]) begin
          if (exp_q.size() == 0) check("R8 unexpected power-up", i, 32'hffff);
          else check("R8 power-up order", i, exp_q.pop_front());
        end
      end
      prev = dom_pwr_en;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  task automatic expect_up(input logic [ND-1:0] mask);
    for (int i = 0; i < ND; i++) if (mask[i]) exp_q.push_back(i);
  endtask

  task automatic send(input logic [1:0] m, input logic full, input logic [ND-1:0] sel);
    @(negedge clk);
    req_valid = 1'b1; req_mode = m; req_full = full; req_dom_sel = sel;
    @(negedge clk);
    req_valid = 1'b0; req_full = 1'b0; req_dom_sel = '0;
  endtask

  task automatic settle();
    do @(negedge clk); while (busy);
    repeat (2) @(negedge clk);
  endtask

  task automatic do_reset();
    pll_lock = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset state while waiting for lock
    check("R1 pll_en", pll_en, 1);
    check("R1 gate closed", clk_gate_en, 0);
    check("R1 domains off", dom_pwr_en, 0);
    check("R1 holds", dom_rst_hold, 4'hf);
    check("R1 busy", busy, 1);
    expect_up(4'hf);
    pll_lock = 1'b1;
    settle();
    check("R1 mode", stat_mode, 0);
    check("R1 gate open", clk_gate_en, 1);
    check("R1 all up", dom_pwr_en, 4'hf);
    check("R11 mask all", stat_pwr_mask, 4'hf);
    check("R1 queue empty", exp_q.size(), 0);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; pg_dly = 3;
    req_valid = 1'b0; req_mode = 2'd0; req_full = 1'b0; req_dom_sel = '0;
    unit_busy = 1'b0;
    do_reset();

    // R2 doze held off while unit busy
    unit_busy = 1'b1;
    send(2'd1, 1'b0, '0);
    repeat (6) @(negedge clk);
    check("R2 held off gate", clk_gate_en, 1);
    check("R2 busy while held", busy, 1);
    unit_busy = 1'b0;
    repeat (2) @(negedge clk);
    check("R4 doze mode", stat_mode, 1);
    check("R4 gate closed", clk_gate_en, 0);
    check("R4 pll on", pll_en, 1);
    check("R4 domains kept", dom_pwr_en, 4'hf);

    // R10 deep sleep request ignored in doze
    send(2'd2, 1'b0, '0);
    repeat (3) @(negedge clk);
    check("R10 doze ignores deep sleep", stat_mode, 1);
    check("R10 pll kept", pll_en, 1);
    send(2'd0, 1'b0, '0);
    @(negedge clk);
    check("R4 doze exit", stat_mode, 0);
    check("R4 gate reopened", clk_gate_en, 1);
    check("R4 no reset", dom_rst_hold, 0);

    // R3 second write while busy ignored
    unit_busy = 1'b1;
    send(2'd1, 1'b0, '0);
    send(2'd3, 1'b1, '0);
    unit_busy = 1'b0;
    repeat (3) @(negedge clk);
    check("R3 first request wins", stat_mode, 1);
    check("R3 domains untouched", dom_pwr_en, 4'hf);
    send(2'd0, 1'b0, '0);
    repeat (2) @(negedge clk);

    // R6 partial power down of domains 0 and 2
    send(2'd3, 1'b0, 4'b0101);
    repeat (2) @(negedge clk);
    check("R6 mode", stat_mode, 3);
    check("R6 enables", dom_pwr_en, 4'b1010);
    check("R6 holds", dom_rst_hold, 4'b0101);
    check("R6 gate open", clk_gate_en, 1);
    check("R11 partial mask", stat_pwr_mask, 4'b1010);
    send(2'd1, 1'b0, '0);
    repeat (2) @(negedge clk);
    check("R10 power down ignores doze", stat_mode, 3);
    expect_up(4'b0101);
    send(2'd0, 1'b0, '0);
    settle();
    check("R8 partial restore", dom_pwr_en, 4'hf);
    check("R9 holds released", dom_rst_hold, 0);
    check("R8 queue empty", exp_q.size(), 0);

    // R7 full power down ignores the selection; slow power-good for R9
    send(2'd3, 1'b1, 4'b0001);
    repeat (2) @(negedge clk);
    check("R7 all off", dom_pwr_en, 0);
    check("R7 all held", dom_rst_hold, 4'hf);
    pg_dly = 20;
    expect_up(4'hf);
    send(2'd0, 1'b0, '0);
    while (!dom_pwr_en[0]) @(negedge clk);
    repeat (10) @(negedge clk);
    check("R9 hold until good", dom_rst_hold[0], 1);
    check("R8 next waits for good", dom_pwr_en[1], 0);
    check("R11 not yet up", stat_pwr_mask, 0);
    settle();
    pg_dly = 3;
    check("R7 restore", dom_pwr_en, 4'hf);
    check("R7 queue empty", exp_q.size(), 0);

    // R5 deep sleep, leave only by hardware reset
    send(2'd2, 1'b0, '0);
    @(negedge clk);
    check("R5 gate first", clk_gate_en, 0);
    check("R5 pll still on", pll_en, 1);
    repeat (2) @(negedge clk);
    check("R5 pll off", pll_en, 0);
    check("R5 mode", stat_mode, 2);
    send(2'd0, 1'b0, '0);
    repeat (3) @(negedge clk);
    check("R5 request ignored", stat_mode, 2);
    check("R5 pll stays off", pll_en, 0);
    do_reset();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule